// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point operands in a four-stage pipeline. Each 32-bit operand uses one sign bit, an 8-bit biased exponent and a 23-bit fraction; the exponent and fraction widths are parameters. A new operation may enter on every clock: the caller raises `in_valid` with `op_a` and `op_b`, and the rounded product comes out four clocks later with `out_valid` high. A valid bit travels through the pipeline next to the data.

The stages work as follows. The first stage unpacks both operands, adds the two biased exponents and takes the bias off once. The second stage multiplies the significands, each with its implicit leading one. The third stage shifts the product so that a single one stands left of the binary point. The fourth stage rounds to nearest with ties to even, renormalizes when rounding carries out, and checks the exponent range. The sign is the XOR of the operand signs and is handled apart from the magnitude. An operand with an exponent field of zero, whether zero or denormal, counts as zero. Infinity and NaN encodings get no special handling.

Top module: `fmul_pipe`

## Requirements
- R1: For non-zero operands, the result's biased exponent is ea + eb − 127, plus one for each normalizing or rounding shift (127 being 2^(EXP_W−1)−1).
- R2: The two 24-bit significands (implicit 1 followed by the 23 fraction bits) are multiplied in full. When the product is 2 or more, it is shifted right one place and the exponent goes up by one.
- R3: The product is rounded to 23 fraction bits, to nearest with ties to even. If rounding carries out to 2.0, the fraction becomes zero and the exponent goes up by one.
- R4: Result bit 31 (the sign) is 1 exactly when the operand sign bits differ. This also holds for zero, overflow and underflow results.
- R5: If either operand has exponent field 0, the result is a signed zero (bits 30:0 all 0), and both flags stay low.
- R6: If the final biased exponent is 255 or more, the result is a signed infinity (exponent field all ones, fraction 0) and `out_ovf` is 1.
- R7: If the final biased exponent is 0 or less, the result is a signed zero and `out_udf` is 1.
- R8: `out_valid` is 1 exactly four clocks after a cycle with `in_valid` 1. One operation is accepted on every clock. After reset, `out_valid` and both flags are 0.
- R9: The product of 0x3F000000 (0.5) and 0xBEE00000 (−0.4375) is 0xBE600000 (−0.21875).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 32 | First operand: sign, biased exponent, fraction |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | `out_prod` and the flags hold a result |
| out_prod | output | 32 | Rounded product |
| out_ovf | output | 1 | Result exponent went over range; the product is infinity |
| out_udf | output | 1 | Result exponent went under range; the product is zero |

## Verification
The main sweep runs an instance with a 4-bit exponent and a 3-bit fraction over every pair of 8-bit operands, back to back. That sweep covers every tie, every rounding carry, both normalization paths, each edge of the exponent range, zero and denormal operands, and both sign combinations, so a mistake in any one rounding or range rule shows up as a specific mismatch. The full-width instance runs directed cases: the worked example, a product of 2 or more, a rounding case at one unit in the last place, overflow, underflow, signed zero and a plain integer product, with idle cycles between some of them so that the four-cycle valid timing is checked across gaps.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
   // Class of a pipeline entry: ordinary number or forced zero.
   typedef enum logic {
      KIND_NUM  = 1'b0,
      KIND_ZERO = 1'b1
   } kind_e;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
   import fmul_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int XW   = EXP_W + 2,
   localparam int SW   = MAN_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [W-1:0]         op_a,
   input  logic [W-1:0]         op_b,
   output logic                 q_valid,
   output logic                 q_sign,
   output kind_e                q_kind,
   output logic signed [XW-1:0] q_exp,
   output logic [SW-1:0]        q_ma,
   output logic [SW-1:0]        q_mb
);
   localparam int BIAS = 2 ** (EXP_W - 1) - 1;

   logic [EXP_W-1:0] ea, eb;
   logic             zero_in;
   logic signed [XW-1:0] exp_sum;

   always_comb begin
      ea      = op_a[W-2 -: EXP_W];
      eb      = op_b[W-2 -: EXP_W];
      zero_in = (ea == '0) || (eb == '0);
      exp_sum = $signed(XW'(ea)) + $signed(XW'(eb)) - $signed(XW'(BIAS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_valid <= 1'b0;
      else        q_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      q_sign <= op_a[W-1] ^ op_b[W-1];
      q_kind <= zero_in ? KIND_ZERO : KIND_NUM;
      q_exp  <= exp_sum;
      q_ma   <= {1'b1, op_a[MAN_W-1:0]};
      q_mb   <= {1'b1, op_b[MAN_W-1:0]};
   end
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul
   import fmul_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int XW   = EXP_W + 2,
   localparam int SW   = MAN_W + 1,
   localparam int PW   = 2 * SW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 d_valid,
   input  logic                 d_sign,
   input  kind_e                d_kind,
   input  logic signed [XW-1:0] d_exp,
   input  logic [SW-1:0]        d_ma,
   input  logic [SW-1:0]        d_mb,
   output logic                 q_valid,
   output logic                 q_sign,
   output kind_e                q_kind,
   output logic signed [XW-1:0] q_exp,
   output logic [PW-1:0]        q_prod
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_valid <= 1'b0;
      else        q_valid <= d_valid;
   end

   always_ff @(posedge clk) begin
      q_sign <= d_sign;
      q_kind <= d_kind;
      q_exp  <= d_exp;
      q_prod <= PW'(d_ma) * PW'(d_mb);
   end
endmodule

// File: rtl/fmul_norm.sv
module fmul_norm
   import fmul_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int XW   = EXP_W + 2,
   localparam int SW   = MAN_W + 1,
   localparam int PW   = 2 * SW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 d_valid,
   input  logic                 d_sign,
   input  kind_e                d_kind,
   input  logic signed [XW-1:0] d_exp,
   input  logic [PW-1:0]        d_prod,
   output logic                 q_valid,
   output logic                 q_sign,
   output kind_e                q_kind,
   output logic signed [XW-1:0] q_exp,
   output logic [SW-1:0]        q_mant,
   output logic                 q_guard,
   output logic                 q_sticky
);
   logic          big;
   logic [PW-1:0] aligned;

   always_comb begin
      big     = d_prod[PW-1];
      aligned = big ? d_prod : (d_prod << 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_valid <= 1'b0;
      else        q_valid <= d_valid;
   end

   always_ff @(posedge clk) begin
      q_sign   <= d_sign;
      q_kind   <= d_kind;
      q_exp    <= d_exp + XW'(big);
      q_mant   <= aligned[PW-1 -: SW];
      q_guard  <= aligned[PW-SW-1];
      q_sticky <= |aligned[PW-SW-2:0];
   end

   // R2: a normalized significand always has its leading one in place
   a_r2_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_kind == KIND_NUM) |-> q_mant[SW-1]);
endmodule

// File: rtl/fmul_round.sv
module fmul_round
   import fmul_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int XW   = EXP_W + 2,
   localparam int SW   = MAN_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 d_valid,
   input  logic                 d_sign,
   input  kind_e                d_kind,
   input  logic signed [XW-1:0] d_exp,
   input  logic [SW-1:0]        d_mant,
   input  logic                 d_guard,
   input  logic                 d_sticky,
   output logic                 out_valid,
   output logic [W-1:0]         out_prod,
   output logic                 out_ovf,
   output logic                 out_udf
);
   localparam logic signed [XW-1:0] EXP_TOP = XW'(2 ** EXP_W - 1);

   logic                 bump;
   logic [SW:0]          rsum;
   logic                 carry;
   logic [MAN_W-1:0]     frac;
   logic signed [XW-1:0] fexp;
   logic                 ovf, udf;
   logic [W-1:0]         packed_res;

   always_comb begin
      bump  = d_guard & (d_sticky | d_mant[0]);
      rsum  = {1'b0, d_mant} + (SW+1)'(bump);
      carry = rsum[SW];
      frac  = carry ? '0 : rsum[MAN_W-1:0];
      fexp  = d_exp + XW'(carry);
      ovf   = (d_kind == KIND_NUM) && (fexp >= EXP_TOP);
      udf   = (d_kind == KIND_NUM) && (fexp[XW-1] || fexp == '0);
      if (d_kind == KIND_ZERO || udf)
         packed_res = {d_sign, {(W-1){1'b0}}};
      else if (ovf)
         packed_res = {d_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else
         packed_res = {d_sign, fexp[EXP_W-1:0], frac};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ovf   <= 1'b0;
         out_udf   <= 1'b0;
      end else begin
         out_valid <= d_valid;
         out_ovf   <= d_valid & ovf;
         out_udf   <= d_valid & udf;
      end
   end

   always_ff @(posedge clk) out_prod <= packed_res;

   // R6: overflow delivers infinity
   a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_prod[W-2 -: EXP_W] == '1 && out_prod[MAN_W-1:0] == '0));
   // R7: underflow delivers zero magnitude
   a_r7_udf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_udf |-> (out_prod[W-2:0] == '0));
   // R6, R7: one range fault at a time
   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ovf && out_udf));
   // R8: flags only accompany a result
   a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ovf || out_udf) |-> out_valid);
endmodule

// File: rtl/fmul_pipe.sv
module fmul_pipe
   import fmul_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic         out_valid,
   output logic [W-1:0] out_prod,
   output logic         out_ovf,
   output logic         out_udf
);
   localparam int XW = EXP_W + 2;
   localparam int SW = MAN_W + 1;
   localparam int PW = 2 * SW;

   generate
      if (EXP_W < 3 || MAN_W < 2) begin : g_bad_cfg
         $error("fmul_pipe: EXP_W must be >= 3 and MAN_W >= 2");
      end
   endgenerate

   logic                 v1, s1, v2, s2, v3, s3, g3, k3_st;
   kind_e                k1, k2, k3;
   logic signed [XW-1:0] e1, e2, e3;
   logic [SW-1:0]        ma1, mb1, m3;
   logic [PW-1:0]        p2;

   fmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .q_valid(v1), .q_sign(s1), .q_kind(k1), .q_exp(e1), .q_ma(ma1), .q_mb(mb1));

   fmul_sigmul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sigmul (
      .clk(clk), .rst_n(rst_n), .d_valid(v1), .d_sign(s1), .d_kind(k1),
      .d_exp(e1), .d_ma(ma1), .d_mb(mb1),
      .q_valid(v2), .q_sign(s2), .q_kind(k2), .q_exp(e2), .q_prod(p2));

   fmul_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .clk(clk), .rst_n(rst_n), .d_valid(v2), .d_sign(s2), .d_kind(k2),
      .d_exp(e2), .d_prod(p2),
      .q_valid(v3), .q_sign(s3), .q_kind(k3), .q_exp(e3), .q_mant(m3),
      .q_guard(g3), .q_sticky(k3_st));

   fmul_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .clk(clk), .rst_n(rst_n), .d_valid(v3), .d_sign(s3), .d_kind(k3),
      .d_exp(e3), .d_mant(m3), .d_guard(g3), .d_sticky(k3_st),
      .out_valid(out_valid), .out_prod(out_prod), .out_ovf(out_ovf), .out_udf(out_udf));

   // R8: an accepted operation emerges four clocks later
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid, 4) && $past(rst_n, 4) && $past(rst_n, 3) &&
       $past(rst_n, 2) && $past(rst_n, 1)) |-> out_valid);
   // R4: sign is the XOR of the operand signs
   a_r4_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_prod[W-1] == $past(op_a[W-1] ^ op_b[W-1], 4)));
   // R5: zero exponent field on an operand forces an unflagged zero
   a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_a[W-2 -: EXP_W] == '0 || op_b[W-2 -: EXP_W] == '0, 4))
      |-> (out_prod[W-2:0] == '0 && !out_ovf && !out_udf));
endmodule

// File: tb/sim_fmul_pipe.sv
module sim_fmul_pipe;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int total = 0;
   int bad   = 0;

   // small configuration: 4-bit exponent, 3-bit fraction
   logic       vs = 1'b0;
   logic [7:0] as_ = '0, bs_ = '0;
   logic       ov_s, pv_s, fo_s, fu_s;
   logic [7:0] pr_s;
   // default configuration
   logic        vd = 1'b0;
   logic [31:0] ad = '0, bd = '0;
   logic        pv_d, fo_d, fu_d;
   logic [31:0] pr_d;

   fmul_pipe #(.EXP_W(4), .MAN_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(vs), .op_a(as_), .op_b(bs_),
      .out_valid(pv_s), .out_prod(pr_s), .out_ovf(fo_s), .out_udf(fu_s));

   fmul_pipe u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(vd), .op_a(ad), .op_b(bd),
      .out_valid(pv_d), .out_prod(pr_d), .out_ovf(fo_d), .out_udf(fu_d));

   assign ov_s = pv_s;

   // arithmetic reference: exact product, rounding by remainder comparison
   function automatic void ref_mul(input int E, input int M,
         input longint unsigned a, input longint unsigned b,
         output longint unsigned r, output bit ov, output bit uf, output bit zin);
      longint unsigned emask = (64'd1 << E) - 1;
      longint unsigned mmask = (64'd1 << M) - 1;
      longint unsigned s  = ((a >> (E + M)) ^ (b >> (E + M))) & 64'd1;
      longint unsigned ea = (a >> M) & emask;
      longint unsigned eb = (b >> M) & emask;
      longint unsigned p, q, rm, half;
      int e, sh;
      ov = 0; uf = 0; zin = 0;
      if (ea == 0 || eb == 0) begin
         zin = 1; r = s << (E + M); return;
      end
      p = ((64'd1 << M) | (a & mmask)) * ((64'd1 << M) | (b & mmask));
      e = int'(ea) + int'(eb) - ((1 << (E - 1)) - 1);
      if (p >= (64'd1 << (2 * M + 1))) begin sh = M + 1; e = e + 1; end
      else sh = M;
      q    = p >> sh;
      rm   = p - (q << sh);
      half = 64'd1 << (sh - 1);
      if (rm > half || (rm == half && q[0])) q = q + 1;
      if (q == (64'd1 << (M + 1))) begin q = 64'd1 << M; e = e + 1; end
      if (e >= int'(emask)) begin
         ov = 1; r = (s << (E + M)) | (emask << M);
      end else if (e <= 0) begin
         uf = 1; r = s << (E + M);
      end else
         r = (s << (E + M)) | (longint'(e) << M) | (q & mmask);
   endfunction

   // expectation history, index 4 is due at the outputs now
   bit          hv_s [1:4];
   logic [7:0]  hr_s [1:4];
   bit          ho_s [1:4], hu_s [1:4];
   string       ht_s [1:4];
   bit          hv_d [1:4];
   logic [31:0] hr_d [1:4];
   bit          ho_d [1:4], hu_d [1:4];
   string       ht_d [1:4];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit nvs, input logic [7:0] na, input logic [7:0] nb,
                       input bit nvd, input logic [31:0] nad, input logic [31:0] nbd,
                       input string tagd);
      longint unsigned r; bit o, u, z;
      @(negedge clk);
      // R8: valid timing on both instances
      chk(ov_s == hv_s[4], "R8 small valid", ov_s, hv_s[4]);
      if (hv_s[4]) begin
         chk(pr_s == hr_s[4], {ht_s[4], " small product"}, pr_s, hr_s[4]);
         chk(fo_s == ho_s[4], "R6 small ovf flag", fo_s, ho_s[4]);
         chk(fu_s == hu_s[4], "R7 small udf flag", fu_s, hu_s[4]);
      end
      chk(pv_d == hv_d[4], "R8 wide valid", pv_d, hv_d[4]);
      if (hv_d[4]) begin
         chk(pr_d == hr_d[4], {ht_d[4], " wide product"}, pr_d, hr_d[4]);
         chk(fo_d == ho_d[4], "R6 wide ovf flag", fo_d, ho_d[4]);
         chk(fu_d == hu_d[4], "R7 wide udf flag", fu_d, hu_d[4]);
      end
      for (int k = 4; k > 1; k--) begin
         hv_s[k] = hv_s[k-1]; hr_s[k] = hr_s[k-1]; ho_s[k] = ho_s[k-1];
         hu_s[k] = hu_s[k-1]; ht_s[k] = ht_s[k-1];
         hv_d[k] = hv_d[k-1]; hr_d[k] = hr_d[k-1]; ho_d[k] = ho_d[k-1];
         hu_d[k] = hu_d[k-1]; ht_d[k] = ht_d[k-1];
      end
      ref_mul(4, 3, longint'(na), longint'(nb), r, o, u, z);
      hv_s[1] = nvs; hr_s[1] = r[7:0]; ho_s[1] = o; hu_s[1] = u;
      ht_s[1] = z ? "R5" : o ? "R6" : u ? "R7" : "R1/R2/R3/R4";
      ref_mul(8, 23, longint'(nad), longint'(nbd), r, o, u, z);
      hv_d[1] = nvd; hr_d[1] = r[31:0]; ho_d[1] = o; hu_d[1] = u; ht_d[1] = tagd;
      vs = nvs; as_ = na; bs_ = nb;
      vd = nvd; ad = nad; bd = nbd;
   endtask

   task automatic wide(input logic [31:0] a, input logic [31:0] b, input string tag);
      step(1'b0, 8'h00, 8'h00, 1'b1, a, b, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 1; k <= 4; k++) begin
         hv_s[k] = 0; hr_s[k] = '0; ho_s[k] = 0; hu_s[k] = 0; ht_s[k] = "";
         hv_d[k] = 0; hr_d[k] = '0; ho_d[k] = 0; hu_d[k] = 0; ht_d[k] = "";
      end
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(!pv_s && !fo_s && !fu_s, "R8 reset small", {pv_s, fo_s, fu_s}, 0);
      chk(!pv_d && !fo_d && !fu_d, "R8 reset wide",  {pv_d, fo_d, fu_d}, 0);
      rst_n = 1'b1;

      wide(32'h3F000000, 32'hBEE00000, "R9");   // 0.5 * -0.4375
      wide(32'h3FC00000, 32'h3FC00000, "R2");   // 1.5 * 1.5, shift path
      step(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, "");
      wide(32'h3F800001, 32'h3F800001, "R3");   // round at one ulp
      wide(32'h3FFFFFFF, 32'h3FFFFFFF, "R3");
      wide(32'h40400000, 32'hC0A00000, "R1/R4"); // 3 * -5
      step(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, "");
      step(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, "");
      wide(32'h7F000000, 32'h7F000000, "R6");
      wide(32'hFF000000, 32'h7F000000, "R6/R4");
      wide(32'h00800000, 32'h00800000, "R7");
      wide(32'h80800000, 32'h00800000, "R7/R4");
      wide(32'h00000001, 32'h3F800000, "R5");   // denormal operand
      wide(32'h80000000, 32'h3F800000, "R5/R4");

      // exhaustive small sweep, back to back
      for (int i = 0; i < 256; i++)
         for (int j = 0; j < 256; j++)
            step(1'b1, 8'(i), 8'(j), 1'b0, '0, '0, "");
      repeat (5) step(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, "");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule